// File: doc/BRIEF.md
# NaN-Boxing Floating-Point Register File

This block is the floating-point register file of a core whose registers are 64 bits wide. It holds 32 entries and serves three formats: half (16 bits), single (32 bits) and double (64 bits). Every write carries a format tag. A value narrower than the register is stored with all bits above its own width forced to one, so the stored word is a quiet NaN when it is seen as a wider number. Double values fill the register and are stored as given.

Two independent read ports each ask for a format and a mode. In the checked mode, used by arithmetic operands, a narrow read returns the low bits only when every bit above them is one. When that padding is missing, the read returns the canonical quiet NaN of the requested format. In the raw mode, used by stores and by moves to the integer side, the low bits come back as stored and nothing is checked. Reads are combinational. Writes land on the rising clock edge. The register file is a random-access array, not a stream, so its ports carry no handshake and never apply back-pressure. A write that is presented is always taken.

Top module: `fp_boxreg_file`

## Requirements
- R1: A write with tag 2'b00 (half) or 2'b01 (single) and `wr_en` high stores the low 16 or 32 bits of `wr_data` with every register bit above them set to one. A raw double read of that entry on the next cycle shows this word.
- R2: A checked narrow read (raw low) of an entry whose bits above the format width are all ones returns the low 16 or 32 bits, zero-extended to 64 bits on the output.
- R3: A checked narrow read of an entry whose upper bits are not all ones returns the canonical NaN of the requested format: 0x7E00 for half, 0x7FC00000 for single. The canonical NaN has sign 0, an all-ones exponent and only the top mantissa bit set.
- R4: A raw narrow read (raw high) returns the low 16 or 32 bits of the entry zero-extended, whatever the upper bits hold.
- R5: Tag 2'b11 (double) is as wide as the register, so it writes and reads the full 64 bits unchanged in both modes.
- R6: Tag 2'b10 (quad) is illegal. On the write port it raises `wr_err` while `wr_en` is high and leaves the array untouched. On a read port it raises that port's error output and drives the data to zero.
- R7: A write takes effect at the rising edge. A read of the same entry in the same cycle returns the previous contents.
- R8: A synchronous reset clears every entry to zero. A checked single read after reset therefore returns 0x7FC00000, and a raw double read returns 0.
- R9: The two read ports work independently, each with its own address, format and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_addr | input | 5 | Entry to write |
| wr_fmt | input | 2 | Format tag of the write |
| wr_data | input | 64 | Write value, low bits used for narrow formats |
| wr_err | output | 1 | Illegal write tag while wr_en is high |
| rd0_addr | input | 5 | Port 0 entry |
| rd0_fmt | input | 2 | Port 0 format tag |
| rd0_raw | input | 1 | Port 0 raw mode (skip unboxing) |
| rd0_data | output | 64 | Port 0 value, zero-extended |
| rd0_err | output | 1 | Port 0 illegal tag |
| rd1_addr | input | 5 | Port 1 entry |
| rd1_fmt | input | 2 | Port 1 format tag |
| rd1_raw | input | 1 | Port 1 raw mode (skip unboxing) |
| rd1_data | output | 64 | Port 1 value, zero-extended |
| rd1_err | output | 1 | Port 1 illegal tag |

## Verification
The one-cycle write-to-read assertions assume that the write and the read happen in the two cycles after reset has been released. Their antecedents require the previous cycle to be out of reset, so a reset that lands between the write and the read cannot trigger them. The post-reset assertion assumes that the cycle before it had reset asserted, which clears every entry. The bench holds every input steady from the falling edge, so combinational reads are stable when sampled. The random stimulus draws tags from all four codes, including the illegal one. It also writes both boxed and unboxed patterns as doubles, so both unboxing outcomes occur often.

// File: rtl/fpbox_pkg.sv
package fpbox_pkg;

  typedef enum logic [1:0] {
    FMT_H = 2'b00,
    FMT_S = 2'b01,
    FMT_Q = 2'b10,
    FMT_D = 2'b11
  } fmt_e;

  // Total width of a format in bits.
  function automatic int fmt_width(input fmt_e f);
    case (f)
      FMT_H:   return 16;
      FMT_S:   return 32;
      FMT_D:   return 64;
      default: return 128;
    endcase
  endfunction

  // Exponent field width of a format.
  function automatic int fmt_expw(input fmt_e f);
    case (f)
      FMT_H:   return 5;
      FMT_S:   return 8;
      FMT_D:   return 11;
      default: return 15;
    endcase
  endfunction

endpackage

// File: rtl/fpbox_fmt_decode.sv
module fpbox_fmt_decode
  import fpbox_pkg::*;
#(
  parameter int FLEN = 64
) (
  input  logic [1:0]      fmt,
  output logic            legal,
  output logic            narrow,
  output logic [FLEN-1:0] lowmask,
  output logic [FLEN-1:0] canon
);
  int w;
  int e;

  always_comb begin
    w       = fmt_width(fmt_e'(fmt));
    e       = fmt_expw(fmt_e'(fmt));
    legal   = (w <= FLEN);
    narrow  = (w < FLEN);
    lowmask = '0;
    canon   = '0;
    for (int i = 0; i < FLEN; i++) begin
      lowmask[i] = (i < w);
      // exponent bits plus the top mantissa bit; sign bit stays zero
      canon[i]   = legal && (i >= w - 2 - e) && (i <= w - 2);
    end
  end
endmodule

// File: rtl/fpbox_boxer.sv
module fpbox_boxer #(
  parameter int FLEN = 64
) (
  input  logic [FLEN-1:0] din,
  input  logic [FLEN-1:0] lowmask,
  output logic [FLEN-1:0] dout
);
  // bits outside the format width are forced high; full width passes through
  always_comb dout = (din & lowmask) | ~lowmask;
endmodule

// File: rtl/fpbox_unboxer.sv
module fpbox_unboxer #(
  parameter int FLEN = 64
) (
  input  logic [FLEN-1:0] stored,
  input  logic            raw,
  input  logic            legal,
  input  logic            narrow,
  input  logic [FLEN-1:0] lowmask,
  input  logic [FLEN-1:0] canon,
  output logic [FLEN-1:0] dout,
  output logic            err
);
  logic pad_ok;

  always_comb begin
    pad_ok = &(stored | lowmask);
    err    = !legal;
    if (!legal)
      dout = '0;
    else if (raw || !narrow || pad_ok)
      dout = stored & lowmask;
    else
      dout = canon;
  end
endmodule

// File: rtl/fpbox_storage.sv
module fpbox_storage #(
  parameter int NUM_REGS = 32,
  parameter int FLEN     = 64,
  parameter int NUM_RD   = 2,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [AW-1:0]             waddr,
  input  logic [FLEN-1:0]           wdata,
  input  logic [NUM_RD-1:0][AW-1:0] raddr,
  output logic [NUM_RD-1:0][FLEN-1:0] rdata
);
  logic [FLEN-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    assign rdata[p] = mem[raddr[p]];
  end
endmodule

// File: rtl/fp_boxreg_file.sv
module fp_boxreg_file #(
  parameter int NUM_REGS = 32,
  parameter int FLEN     = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [$clog2(NUM_REGS)-1:0] wr_addr,
  input  logic [1:0]                  wr_fmt,
  input  logic [FLEN-1:0]             wr_data,
  output logic                        wr_err,
  input  logic [$clog2(NUM_REGS)-1:0] rd0_addr,
  input  logic [1:0]                  rd0_fmt,
  input  logic                        rd0_raw,
  output logic [FLEN-1:0]             rd0_data,
  output logic                        rd0_err,
  input  logic [$clog2(NUM_REGS)-1:0] rd1_addr,
  input  logic [1:0]                  rd1_fmt,
  input  logic                        rd1_raw,
  output logic [FLEN-1:0]             rd1_data,
  output logic                        rd1_err
);
  localparam int AW     = $clog2(NUM_REGS);
  localparam int NUM_RD = 2;

  // write path
  logic            w_legal, w_narrow;
  logic [FLEN-1:0] w_mask, w_canon, w_boxed;

  fpbox_fmt_decode #(.FLEN(FLEN)) u_wdec (
    .fmt(wr_fmt), .legal(w_legal), .narrow(w_narrow),
    .lowmask(w_mask), .canon(w_canon)
  );

  fpbox_boxer #(.FLEN(FLEN)) u_box (
    .din(wr_data), .lowmask(w_mask), .dout(w_boxed)
  );

  assign wr_err = wr_en && !w_legal;

  // read request bundling
  logic [NUM_RD-1:0][AW-1:0]   r_addr;
  logic [NUM_RD-1:0][1:0]      r_fmt;
  logic [NUM_RD-1:0]           r_raw;
  logic [NUM_RD-1:0][FLEN-1:0] r_word, r_out;
  logic [NUM_RD-1:0]           r_err;

  assign r_addr = {rd1_addr, rd0_addr};
  assign r_fmt  = {rd1_fmt, rd0_fmt};
  assign r_raw  = {rd1_raw, rd0_raw};

  fpbox_storage #(.NUM_REGS(NUM_REGS), .FLEN(FLEN), .NUM_RD(NUM_RD)) u_mem (
    .clk(clk), .rst(rst), .we(wr_en && w_legal), .waddr(wr_addr),
    .wdata(w_boxed), .raddr(r_addr), .rdata(r_word)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_port
    logic            legal, narrow;
    logic [FLEN-1:0] mask, canon;

    fpbox_fmt_decode #(.FLEN(FLEN)) u_rdec (
      .fmt(r_fmt[p]), .legal(legal), .narrow(narrow),
      .lowmask(mask), .canon(canon)
    );

    fpbox_unboxer #(.FLEN(FLEN)) u_unbox (
      .stored(r_word[p]), .raw(r_raw[p]), .legal(legal), .narrow(narrow),
      .lowmask(mask), .canon(canon), .dout(r_out[p]), .err(r_err[p])
    );
  end

  assign rd0_data = r_out[0];
  assign rd1_data = r_out[1];
  assign rd0_err  = r_err[0];
  assign rd1_err  = r_err[1];

  // reuse of write-side narrow/canon only for completeness of decode
  logic unused_w;
  assign unused_w = w_narrow ^ (^w_canon);
endmodule

// File: rtl/fpbox_checker.sv
module fpbox_checker #(
  parameter int NUM_REGS = 32,
  parameter int FLEN     = 64
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        wr_en,
  input logic [$clog2(NUM_REGS)-1:0] wr_addr,
  input logic [1:0]                  wr_fmt,
  input logic [FLEN-1:0]             wr_data,
  input logic                        wr_err,
  input logic [$clog2(NUM_REGS)-1:0] rd0_addr,
  input logic [1:0]                  rd0_fmt,
  input logic                        rd0_raw,
  input logic [FLEN-1:0]             rd0_data,
  input logic                        rd0_err,
  input logic [$clog2(NUM_REGS)-1:0] rd1_addr,
  input logic [1:0]                  rd1_fmt,
  input logic                        rd1_raw,
  input logic [FLEN-1:0]             rd1_data,
  input logic                        rd1_err
);
  assert_wr_err_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_fmt == 2'b10) |-> wr_err);

  assert_rd_illegal_R6: assert property (@(posedge clk) disable iff (rst)
    (rd0_fmt == 2'b10) |-> (rd0_err && rd0_data == '0));

  assert_double_next_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(wr_en && wr_fmt == 2'b11) && rd0_fmt == 2'b11 &&
     rd0_addr == $past(wr_addr)) |-> (rd0_data == $past(wr_data)));

  assert_single_box_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(wr_en && wr_fmt == 2'b01) && rd1_fmt == 2'b11 &&
     rd1_addr == $past(wr_addr)) |-> (rd1_data == {32'hFFFF_FFFF, $past(wr_data[31:0])}));

  assert_after_reset_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && rd0_fmt == 2'b01 && !rd0_raw) |-> (rd0_data == 64'h7FC0_0000));

  assert_raw_zext_R4: assert property (@(posedge clk) disable iff (rst)
    (rd1_raw && rd1_fmt == 2'b00) |-> (rd1_data[FLEN-1:16] == '0 && !rd1_err));
endmodule

bind fp_boxreg_file fpbox_checker #(.NUM_REGS(NUM_REGS), .FLEN(FLEN)) chk_i (.*);

// File: tb/fp_boxreg_file_tb_top.sv
module fp_boxreg_file_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [1:0]  wr_fmt;
  logic [63:0] wr_data;
  logic        wr_err;
  logic [4:0]  rd0_addr, rd1_addr;
  logic [1:0]  rd0_fmt, rd1_fmt;
  logic        rd0_raw, rd1_raw;
  logic [63:0] rd0_data, rd1_data;
  logic        rd0_err, rd1_err;

  logic [63:0] model [32];
  int nchk  = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  fp_boxreg_file dut_i (.*);

  function automatic logic [63:0] exp_box(input logic [1:0] f, input logic [63:0] d);
    case (f)
      2'b00:   return {48'hFFFF_FFFF_FFFF, d[15:0]};
      2'b01:   return {32'hFFFF_FFFF, d[31:0]};
      default: return d;
    endcase
  endfunction

  function automatic logic [63:0] exp_read(input logic [63:0] w, input logic [1:0] f,
                                           input logic raw);
    case (f)
      2'b00: if (!raw && w[63:16] != 48'hFFFF_FFFF_FFFF) return 64'h7E00;
             else return {48'h0, w[15:0]};
      2'b01: if (!raw && w[63:32] != 32'hFFFF_FFFF) return 64'h7FC0_0000;
             else return {32'h0, w[31:0]};
      2'b11: return w;
      default: return 64'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // inputs are set at a falling edge; check reads, then commit at the rising edge
  task automatic cycle(input string tag);
    #1;
    chk({tag, " R9 port0"}, rd0_data, exp_read(model[rd0_addr], rd0_fmt, rd0_raw));
    chk({tag, " R9 port1"}, rd1_data, exp_read(model[rd1_addr], rd1_fmt, rd1_raw));
    chk({tag, " R6 errs"}, {61'h0, wr_err, rd0_err, rd1_err},
        {61'h0, wr_en && wr_fmt == 2'b10, rd0_fmt == 2'b10, rd1_fmt == 2'b10});
    @(posedge clk);
    if (!rst && wr_en && wr_fmt != 2'b10) model[wr_addr] = exp_box(wr_fmt, wr_data);
    @(negedge clk);
  endtask

  task automatic setw(input logic en, input logic [4:0] a, input logic [1:0] f,
                      input logic [63:0] d);
    wr_en = en; wr_addr = a; wr_fmt = f; wr_data = d;
  endtask

  task automatic setr(input int p, input logic [4:0] a, input logic [1:0] f, input logic raw);
    if (p == 0) begin rd0_addr = a; rd0_fmt = f; rd0_raw = raw; end
    else        begin rd1_addr = a; rd1_fmt = f; rd1_raw = raw; end
  endtask

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int unsigned seed = 32'd1234;
    void'($urandom(seed));
    for (int i = 0; i < 32; i++) model[i] = 64'h0;
    rst = 1'b1;
    setw(0, 0, 0, 0); setr(0, 0, 0, 0); setr(1, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R8: reset contents
    setr(0, 5'd5, 2'b01, 0); setr(1, 5'd5, 2'b11, 1);
    #1;
    chk("R8 checked single after reset", rd0_data, 64'h7FC0_0000);
    chk("R8 raw double after reset", rd1_data, 64'h0);
    cycle("R8");

    // R1, R2: single write then reads
    setw(1, 5'd1, 2'b01, 64'hDEAD_BEEF_3F80_0000);
    cycle("R1 write");
    setw(0, 0, 0, 0);
    setr(0, 5'd1, 2'b01, 0); setr(1, 5'd1, 2'b11, 1);
    #1;
    chk("R2 checked single", rd0_data, 64'h3F80_0000);
    chk("R1 boxed word", rd1_data, 64'hFFFF_FFFF_3F80_0000);
    cycle("R1 read");

    // R3 / R4: half reads of a single-boxed entry
    setr(0, 5'd1, 2'b00, 0); setr(1, 5'd1, 2'b00, 1);
    #1;
    chk("R3 canonical half", rd0_data, 64'h7E00);
    chk("R4 raw half", rd1_data, 64'h0000);
    cycle("R3");

    // R2: half written, single checked read sees valid box
    setw(1, 5'd2, 2'b00, 64'h1234_3C00);
    cycle("R2 write");
    setw(0, 0, 0, 0);
    setr(0, 5'd2, 2'b01, 0); setr(1, 5'd2, 2'b00, 0);
    #1;
    chk("R2 single over half box", rd0_data, 64'hFFFF_3C00);
    chk("R2 checked half", rd1_data, 64'h3C00);
    cycle("R2 read");

    // R5 and R7: double write, same-cycle read sees old, next sees new
    setw(1, 5'd3, 2'b11, 64'h4009_21FB_5444_2D18);
    setr(0, 5'd3, 2'b11, 0); setr(1, 5'd3, 2'b01, 0);
    #1;
    chk("R7 same-cycle old value", rd0_data, 64'h0);
    cycle("R7");
    setw(0, 0, 0, 0);
    setr(0, 5'd3, 2'b11, 0); setr(1, 5'd3, 2'b01, 0);
    #1;
    chk("R5 double passthrough", rd0_data, 64'h4009_21FB_5444_2D18);
    chk("R3 canonical single", rd1_data, 64'h7FC0_0000);
    cycle("R5");

    // R6: illegal write leaves entry 3 untouched
    setw(1, 5'd3, 2'b10, 64'h1111_2222_3333_4444);
    setr(0, 5'd3, 2'b10, 0); setr(1, 5'd3, 2'b10, 1);
    #1;
    chk("R6 write error flag", {63'h0, wr_err}, 64'h1);
    chk("R6 read data zero", rd0_data, 64'h0);
    cycle("R6");
    setw(0, 0, 0, 0);
    setr(0, 5'd3, 2'b11, 1);
    #1;
    chk("R6 entry unchanged", rd0_data, 64'h4009_21FB_5444_2D18);
    cycle("R6 after");

    // random mix: R1 R2 R3 R4 R5 R9
    for (int n = 0; n < 600; n++) begin
      logic [63:0] d;
      d = {$urandom, $urandom};
      if ($urandom % 4 == 0) d[63:32] = 32'hFFFF_FFFF;
      if ($urandom % 4 == 0) d[63:16] = 48'hFFFF_FFFF_FFFF;
      setw(1'($urandom), 5'($urandom), 2'($urandom), d);
      setr(0, 5'($urandom), 2'($urandom), 1'($urandom));
      setr(1, 5'($urandom), 2'($urandom), 1'($urandom));
      cycle("random");
    end

    // R8: reset again clears everything
    setw(0, 0, 0, 0);
    rst = 1'b1;
    @(posedge clk);
    for (int i = 0; i < 32; i++) model[i] = 64'h0;
    @(negedge clk);
    rst = 1'b0;
    setr(0, 5'd1, 2'b01, 0); setr(1, 5'd3, 2'b11, 0);
    #1;
    chk("R8 second reset single", rd0_data, 64'h7FC0_0000);
    chk("R8 second reset double", rd1_data, 64'h0);
    cycle("R8 end");

    $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule